// File: doc/BRIEF.md
# Instruction Prefix Scanner

This block sits at the front of an instruction length and attribute decoder. It receives the bytes of one instruction, one byte per cycle over a valid/ready stream, and works through everything that comes before the opcode. First come the legacy prefixes. In 64-bit mode an optional REX byte may follow. After that comes an optional two- or three-byte VEX prefix. The block accepts the first opcode byte, reports it, and stops. While it scans, it keeps the effective address and operand sizes up to date. It also records each distinct legacy prefix, keeps the most recent prefix in the top slot, and stores a two-byte VEX prefix in the same three-byte layout as a long one.

A `start` pulse begins a new instruction and samples the mode flag. Once the scan ends, exactly one of three outcomes holds until the next `start`:
- `done`: the opcode byte was taken.
- `trunc_err`: the stream ended before an opcode.
- `excess_err`: too many distinct prefixes.

While it holds an outcome, the block takes no input. Outside 64-bit mode a VEX lead byte is only a prefix if the byte after it looks like a register-form operand byte. The block inspects that following byte on the stream without accepting it. If the test fails, the lead byte is reported as the opcode and the following byte is left on the stream for the next stage.

Top module: `pfx_scan`

## Requirements
- R1: After reset, `done`, `trunc_err`, `excess_err`, `in_ready` and `pfx_cnt` are 0, and both sizes read 4. A `start` pulse sets the address size to 8 when `mode64` is 1 and to 4 when it is 0, and sets the operand size to 4.
- R2: The first 0x67 byte of an instruction flips the address size between 8 and 4 in 64-bit mode, and between 4 and 2 otherwise.
- R3: The first 0x66 byte flips the operand size between 4 and 2.
- R4: The legacy prefix values are 0x26, 0x2E, 0x36, 0x3E, 0x64, 0x65, 0x66, 0x67, 0xF0, 0xF2 and 0xF3. A legacy byte equal to one already recorded is accepted but not stored again, and it changes neither size. `pfx_cnt` counts distinct stored prefixes.
- R5: At most four distinct prefixes are stored. A fifth distinct one is accepted, raises `excess_err` on the next cycle, and `done` stays low.
- R6: Stored slot i appears on `pfx_slots[8i+7:8i]`, in arrival order. When the scan ends, the last prefix byte seen (repeats included) sits in slot 3. If slot 3 held a different nonzero byte, that byte replaces every other slot that held the last prefix. If slot 3 was empty, the other slots are unchanged. `last_pfx` shows the last prefix byte.
- R7: In 64-bit mode a byte 0x40..0x4F after the legacy prefixes is taken as REX. It sets `rex_seen` and `rex_byte`, and if bit 3 is 1 the operand size becomes 8. Outside 64-bit mode such bytes are opcodes. A legacy value after REX is an opcode.
- R8: 0xC4 (long form) and 0xC5 (short form) lead a VEX prefix. Outside 64-bit mode this holds only if the next byte has bits [7:6] = 11. Otherwise the lead byte becomes the opcode and the next byte is not accepted. A lead byte flagged last outside 64-bit mode is an opcode.
- R9: `vex_len` is 2 or 3 after a VEX prefix and 0 otherwise. `vex_bytes` holds byte k at [8k+7:8k] and reads 0 when `vex_len` is 0. For the short form, byte 2 is byte 1 AND 0x7F. For the long form in 64-bit mode, bit 7 of byte 2 set makes the operand size 8.
- R10: If a prefix, REX or VEX byte is accepted with `in_last` set, `trunc_err` rises and `done` stays low.
- R11: The opcode byte is accepted, `done` rises the next cycle with `opcode` holding it, and `in_ready` stays low while any outcome holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin a new instruction; samples `mode64` |
| mode64 | input | 1 | 64-bit mode flag |
| in_valid | input | 1 | Stream byte valid |
| in_data | input | 8 | Stream byte |
| in_last | input | 1 | Byte is the last of the stream |
| in_ready | output | 1 | Byte accepted when high with `in_valid` |
| done | output | 1 | Opcode reached |
| trunc_err | output | 1 | Stream ended before the opcode |
| excess_err | output | 1 | Fifth distinct prefix seen |
| opcode | output | 8 | First opcode byte |
| pfx_slots | output | 32 | Prefix slots, slot i at [8i+7:8i] |
| pfx_cnt | output | 3 | Number of distinct stored prefixes |
| last_pfx | output | 8 | Last prefix byte seen |
| addr_size | output | 4 | Effective address size in bytes |
| opnd_size | output | 4 | Effective operand size in bytes |
| rex_seen | output | 1 | REX byte present |
| rex_byte | output | 8 | REX byte |
| vex_len | output | 2 | VEX prefix length (0, 2 or 3) |
| vex_bytes | output | 24 | VEX bytes, byte k at [8k+7:8k] |

## Verification
The hardest case to reach from the ports is the slot-3 swap. It needs all four slots full and a final prefix byte that repeats an earlier one. Only then does the top slot's old content move into a lower slot. The bench gets there by rotating through the prefix table, feeding four distinct values and then repeating the first. It also sweeps every ordered pair of prefixes in both modes, which covers the duplicate and single-slot cases. The non-accepted look-ahead after a VEX lead byte outside 64-bit mode is checked by counting accepted bytes. The sweep varies the top two bits of the following byte.

// File: rtl/pfx_scan_pkg.sv
package pfx_scan_pkg;

  localparam int SZW = 4;

  localparam logic [7:0] VEX_LONG_LEAD  = 8'hC4;
  localparam logic [7:0] VEX_SHORT_LEAD = 8'hC5;
  localparam logic [7:0] ASZ_BYTE       = 8'h67;
  localparam logic [7:0] OSZ_BYTE       = 8'h66;
  localparam logic [SZW-1:0] OPND_DEF   = 4'd4;

  typedef enum logic [3:0] {
    ST_IDLE, ST_LEG, ST_REXD, ST_VEX1, ST_VEX2, ST_OPC,
    ST_DONE, ST_TRUNC, ST_EXCESS
  } scan_st_e;

  function automatic logic is_legacy(input logic [7:0] b);
    case (b)
      8'h26, 8'h2E, 8'h36, 8'h3E, 8'h64, 8'h65,
      8'h66, 8'h67, 8'hF0, 8'hF2, 8'hF3: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic is_rex(input logic [7:0] b, input logic m64);
    return m64 && (b[7:4] == 4'h4);
  endfunction

  function automatic logic is_vex_lead(input logic [7:0] b);
    return (b == VEX_LONG_LEAD) || (b == VEX_SHORT_LEAD);
  endfunction

  function automatic logic mod_is_reg(input logic [7:0] b);
    return b[7:6] == 2'b11;
  endfunction

  function automatic logic [SZW-1:0] addr_default(input logic m64);
    return m64 ? 4'd8 : 4'd4;
  endfunction

  // 8 <-> 4 in 64-bit mode, 4 <-> 2 otherwise
  function automatic logic [SZW-1:0] addr_flip(input logic [SZW-1:0] a, input logic m64);
    return m64 ? (a ^ 4'd12) : (a ^ 4'd6);
  endfunction

  function automatic logic [SZW-1:0] opnd_flip(input logic [SZW-1:0] o);
    return o ^ 4'd6;
  endfunction

endpackage

// File: rtl/pfx_slot_store.sv
module pfx_slot_store #(
  parameter int NSLOT = 4,
  localparam int CW = $clog2(NSLOT + 1),
  localparam int LAST = NSLOT - 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              take,
  input  logic [7:0]        din,
  output logic              hit,
  output logic              full,
  output logic [CW-1:0]     cnt,
  output logic [7:0]        last_byte,
  output logic [NSLOT*8-1:0] slots
);

  logic [7:0] raw [NSLOT];
  logic [7:0] fixed [NSLOT];
  logic [NSLOT-1:0] match;

  genvar g;
  generate
    for (g = 0; g < NSLOT; g++) begin : g_cmp
      assign match[g] = (cnt > CW'(g)) && (raw[g] == din);
      assign slots[8*g +: 8] = fixed[g];
    end
  endgenerate

  assign hit  = |match;
  assign full = (cnt == CW'(NSLOT));

  wire store = take && !hit && !full;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      for (int i = 0; i < NSLOT; i++) raw[i] <= 8'h00;
      cnt       <= '0;
      last_byte <= 8'h00;
    end else if (take) begin
      last_byte <= din;
      if (store) begin
        for (int i = 0; i < NSLOT; i++)
          if (cnt == CW'(i)) raw[i] <= din;
        cnt <= cnt + 1'b1;
      end
    end
  end

  // Move the most recent prefix into the top slot
  always_comb begin
    for (int i = 0; i < NSLOT; i++) fixed[i] = raw[i];
    if (last_byte != 8'h00 && last_byte != raw[LAST]) begin
      if (raw[LAST] != 8'h00)
        for (int i = 0; i < NSLOT; i++)
          if (raw[i] == last_byte) fixed[i] = raw[LAST];
      fixed[LAST] = last_byte;
    end
  end

endmodule

// File: rtl/pfx_size_track.sv
module pfx_size_track import pfx_scan_pkg::*; (
  input  logic           clk,
  input  logic           rst,
  input  logic           clr,
  input  logic           mode_in,
  input  logic           flip_addr,
  input  logic           flip_opnd,
  input  logic           force_wide,
  output logic [SZW-1:0] addr_size,
  output logic [SZW-1:0] opnd_size
);

  logic mode_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q    <= 1'b0;
      addr_size <= 4'd4;
      opnd_size <= OPND_DEF;
    end else if (clr) begin
      mode_q    <= mode_in;
      addr_size <= addr_default(mode_in);
      opnd_size <= OPND_DEF;
    end else begin
      if (flip_addr) addr_size <= addr_flip(addr_size, mode_q);
      if (force_wide) opnd_size <= 4'd8;
      else if (flip_opnd) opnd_size <= opnd_flip(opnd_size);
    end
  end

endmodule

// File: rtl/pfx_ext_capture.sv
module pfx_ext_capture import pfx_scan_pkg::*; (
  input  logic        clk,
  input  logic        rst,
  input  logic        clr,
  input  logic        rex_we,
  input  logic        lead_we,
  input  logic        v1_we,
  input  logic        v2_we,
  input  logic [7:0]  din,
  output logic        rex_seen,
  output logic [7:0]  rex_byte,
  output logic [7:0]  lead_raw,
  output logic [1:0]  vex_len,
  output logic [23:0] vex_bytes
);

  logic [7:0] v1_q, v2_q;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      rex_seen <= 1'b0;
      rex_byte <= 8'h00;
      lead_raw <= 8'h00;
      v1_q     <= 8'h00;
      v2_q     <= 8'h00;
      vex_len  <= 2'd0;
    end else begin
      if (rex_we) begin
        rex_seen <= 1'b1;
        rex_byte <= din;
      end
      if (lead_we) lead_raw <= din;
      if (v1_we) begin
        v1_q <= din;
        if (lead_raw == VEX_SHORT_LEAD) begin
          v2_q    <= din & 8'h7F;
          vex_len <= 2'd2;
        end
      end
      if (v2_we) begin
        v2_q    <= din;
        vex_len <= 2'd3;
      end
    end
  end

  assign vex_bytes = (vex_len == 2'd0) ? 24'h0 : {v2_q, v1_q, lead_raw};

endmodule

// File: rtl/pfx_scan.sv
module pfx_scan import pfx_scan_pkg::*; #(
  parameter int NSLOT = 4,
  localparam int CW = $clog2(NSLOT + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic               mode64,
  input  logic               in_valid,
  input  logic [7:0]         in_data,
  input  logic               in_last,
  output logic               in_ready,
  output logic               done,
  output logic               trunc_err,
  output logic               excess_err,
  output logic [7:0]         opcode,
  output logic [NSLOT*8-1:0] pfx_slots,
  output logic [CW-1:0]      pfx_cnt,
  output logic [7:0]         last_pfx,
  output logic [SZW-1:0]     addr_size,
  output logic [SZW-1:0]     opnd_size,
  output logic               rex_seen,
  output logic [7:0]         rex_byte,
  output logic [1:0]         vex_len,
  output logic [23:0]        vex_bytes
);

  scan_st_e st_q, st_d;
  logic m64_q;
  logic [7:0] opc_q;
  logic base_ready;
  logic hit, full;
  logic [7:0] lead_raw;

  always_comb begin
    case (st_q)
      ST_LEG, ST_REXD, ST_VEX2, ST_OPC: base_ready = 1'b1;
      ST_VEX1: base_ready = m64_q || mod_is_reg(in_data);
      default: base_ready = 1'b0;
    endcase
  end

  assign in_ready = base_ready && !start;
  wire take = in_valid && in_ready;

  // byte classes in the lead-in phases
  wire pfx_phase = (st_q == ST_LEG);
  wire lead_phase = (st_q == ST_LEG) || (st_q == ST_REXD);
  wire cls_leg = pfx_phase && is_legacy(in_data);
  wire cls_rex = pfx_phase && !cls_leg && is_rex(in_data, m64_q);
  wire cls_vex = lead_phase && is_vex_lead(in_data);
  wire cls_op  = lead_phase && !cls_leg && !cls_rex && !cls_vex;

  // named events
  wire pfx_take   = take && cls_leg;
  wire dup_take   = pfx_take && hit;
  wire new_pfx    = pfx_take && !hit && !full;
  wire over_pfx   = pfx_take && !hit && full;
  wire rex_take   = take && cls_rex;
  wire lead_take  = take && cls_vex;
  wire lone_lead  = lead_take && !m64_q && in_last;
  wire vex_reject = (st_q == ST_VEX1) && !m64_q && in_valid && !start && !mod_is_reg(in_data);
  wire v1_take    = take && (st_q == ST_VEX1);
  wire v2_take    = take && (st_q == ST_VEX2);
  wire op_take    = take && (cls_op || st_q == ST_OPC);
  wire opc_we     = op_take || lone_lead || vex_reject;
  wire wide_req   = (rex_take && in_data[3]) || (v2_take && m64_q && in_data[7]);

  always_comb begin
    st_d = st_q;
    if (start) st_d = ST_LEG;
    else begin
      case (st_q)
        ST_LEG, ST_REXD: if (take) begin
          if (cls_leg)      st_d = over_pfx ? ST_EXCESS : (in_last ? ST_TRUNC : ST_LEG);
          else if (cls_rex) st_d = in_last ? ST_TRUNC : ST_REXD;
          else if (cls_vex) st_d = !in_last ? ST_VEX1 : (m64_q ? ST_TRUNC : ST_DONE);
          else              st_d = ST_DONE;
        end
        ST_VEX1: begin
          if (vex_reject) st_d = ST_DONE;
          else if (take)
            st_d = in_last ? ST_TRUNC : ((lead_raw == VEX_LONG_LEAD) ? ST_VEX2 : ST_OPC);
        end
        ST_VEX2: if (take) st_d = in_last ? ST_TRUNC : ST_OPC;
        ST_OPC:  if (take) st_d = ST_DONE;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= ST_IDLE;
      m64_q <= 1'b0;
      opc_q <= 8'h00;
    end else begin
      st_q <= st_d;
      if (start) begin
        m64_q <= mode64;
        opc_q <= 8'h00;
      end else if (opc_we) begin
        opc_q <= vex_reject ? lead_raw : in_data;
      end
    end
  end

  pfx_slot_store #(.NSLOT(NSLOT)) u_store (
    .clk(clk), .rst(rst), .clr(start), .take(pfx_take), .din(in_data),
    .hit(hit), .full(full), .cnt(pfx_cnt), .last_byte(last_pfx), .slots(pfx_slots)
  );

  pfx_size_track u_size (
    .clk(clk), .rst(rst), .clr(start), .mode_in(mode64),
    .flip_addr(new_pfx && in_data == ASZ_BYTE),
    .flip_opnd(new_pfx && in_data == OSZ_BYTE),
    .force_wide(wide_req),
    .addr_size(addr_size), .opnd_size(opnd_size)
  );

  pfx_ext_capture u_ext (
    .clk(clk), .rst(rst), .clr(start), .rex_we(rex_take), .lead_we(lead_take),
    .v1_we(v1_take), .v2_we(v2_take), .din(in_data),
    .rex_seen(rex_seen), .rex_byte(rex_byte), .lead_raw(lead_raw),
    .vex_len(vex_len), .vex_bytes(vex_bytes)
  );

  assign done       = (st_q == ST_DONE);
  assign trunc_err  = (st_q == ST_TRUNC);
  assign excess_err = (st_q == ST_EXCESS);
  assign opcode     = opc_q;

endmodule

// File: rtl/pfx_scan_chk.sv
module pfx_scan_chk #(
  parameter int NSLOT = 4,
  localparam int CW = $clog2(NSLOT + 1)
) (
  input logic          clk,
  input logic          rst,
  input logic          start,
  input logic          in_ready,
  input logic          done,
  input logic          trunc_err,
  input logic          excess_err,
  input logic [7:0]    opcode,
  input logic [CW-1:0] pfx_cnt,
  input logic [3:0]    addr_size,
  input logic [3:0]    opnd_size,
  input logic [1:0]    vex_len,
  input logic [23:0]   vex_bytes,
  input logic          dup_take,
  input logic          over_pfx
);

  // R11
  done_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (done || trunc_err || excess_err) |-> !in_ready);

  // R10
  one_outcome_chk: assert property (@(posedge clk) disable iff (rst)
    $countones({done, trunc_err, excess_err}) <= 1);

  // R3
  opnd_legal_chk: assert property (@(posedge clk) disable iff (rst)
    (opnd_size == 4'd2) || (opnd_size == 4'd4) || (opnd_size == 4'd8));

  // R2
  addr_legal_chk: assert property (@(posedge clk) disable iff (rst)
    (addr_size == 4'd2) || (addr_size == 4'd4) || (addr_size == 4'd8));

  // R5
  excess_follow_chk: assert property (@(posedge clk) disable iff (rst)
    over_pfx |=> excess_err);

  // R5
  cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
    pfx_cnt <= CW'(NSLOT));

  // R4
  dup_hold_chk: assert property (@(posedge clk) disable iff (rst)
    dup_take |=> ($stable(pfx_cnt) && $stable(opnd_size) && $stable(addr_size)));

  // R9
  vex2_w_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (vex_len == 2'd2) |-> !vex_bytes[23]);

  // R11
  done_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (done && !start) |=> (done && $stable(opcode)));

endmodule

bind pfx_scan pfx_scan_chk #(.NSLOT(NSLOT)) u_chk (
  .clk(clk), .rst(rst), .start(start), .in_ready(in_ready), .done(done),
  .trunc_err(trunc_err), .excess_err(excess_err), .opcode(opcode),
  .pfx_cnt(pfx_cnt), .addr_size(addr_size), .opnd_size(opnd_size),
  .vex_len(vex_len), .vex_bytes(vex_bytes), .dup_take(dup_take),
  .over_pfx(over_pfx)
);

// File: tb/pfx_scan_test.sv
`timescale 1ns/1ps
module pfx_scan_test;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst, start, mode64, in_valid, in_last;
  logic [7:0] in_data;
  logic in_ready, done, trunc_err, excess_err, rex_seen;
  logic [7:0] opcode, last_pfx, rex_byte;
  logic [31:0] pfx_slots;
  logic [2:0] pfx_cnt;
  logic [3:0] addr_size, opnd_size;
  logic [1:0] vex_len;
  logic [23:0] vex_bytes;

  pfx_scan uut (
    .clk(clk), .rst(rst), .start(start), .mode64(mode64), .in_valid(in_valid),
    .in_data(in_data), .in_last(in_last), .in_ready(in_ready), .done(done),
    .trunc_err(trunc_err), .excess_err(excess_err), .opcode(opcode),
    .pfx_slots(pfx_slots), .pfx_cnt(pfx_cnt), .last_pfx(last_pfx),
    .addr_size(addr_size), .opnd_size(opnd_size), .rex_seen(rex_seen),
    .rex_byte(rex_byte), .vex_len(vex_len), .vex_bytes(vex_bytes)
  );

  int n_run = 0, n_fail = 0;
  logic [7:0] lp [11] = '{8'hF3, 8'h26, 8'h67, 8'hF0, 8'h3E, 8'h66, 8'h65, 8'h2E, 8'hF2, 8'h36, 8'h64};
  logic [7:0] sb [0:15];
  int sn;

  // expected values
  bit e_done, e_trunc, e_exc, e_rexs;
  logic [7:0] e_opc, e_last, e_rex, v0, v1, v2;
  logic [7:0] es [4];
  int e_cnt, e_cons, e_addr, e_opnd, e_vlen;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic bit is_lp(input logic [7:0] b);
    for (int k = 0; k < 11; k++) if (lp[k] == b) return 1'b1;
    return 1'b0;
  endfunction

  task automatic put(input logic [7:0] b);
    sb[sn] = b;
    sn++;
  endtask

  task automatic model(input bit m);
    int nb, i;
    bit dup;
    logic [7:0] b, top;
    nb = 0; i = 0;
    e_done = 0; e_trunc = 0; e_exc = 0; e_rexs = 0; e_rex = 0; e_opc = 0;
    e_addr = m ? 8 : 4; e_opnd = 4; e_vlen = 0; e_last = 0;
    v0 = 0; v1 = 0; v2 = 0;
    for (int k = 0; k < 4; k++) es[k] = 0;
    while (i < sn && is_lp(sb[i])) begin
      b = sb[i];
      dup = 0;
      for (int k = 0; k < nb; k++) if (es[k] == b) dup = 1;
      if (!dup) begin
        if (nb == 4) begin e_exc = 1; e_cons = i + 1; return; end
        es[nb] = b; nb++;
        if (b == 8'h67) e_addr = m ? ((e_addr == 8) ? 4 : 8) : ((e_addr == 4) ? 2 : 4);
        if (b == 8'h66) e_opnd = (e_opnd == 4) ? 2 : 4;
      end
      e_last = b; i++;
    end
    e_cnt = nb;
    if (i == sn) begin e_trunc = 1; e_cons = sn; return; end
    if (e_last != 0 && e_last != es[3]) begin
      top = es[3];
      if (top != 0) for (int k = 0; k < 4; k++) if (es[k] == e_last) es[k] = top;
      es[3] = e_last;
    end
    if (m && sb[i][7:4] == 4'h4) begin
      e_rexs = 1; e_rex = sb[i];
      if (sb[i][3]) e_opnd = 8;
      i++;
      if (i == sn) begin e_trunc = 1; e_cons = sn; return; end
    end
    if (sb[i] == 8'hC4 || sb[i] == 8'hC5) begin
      if (!m && !(i + 1 < sn && sb[i+1][7:6] == 2'b11)) begin
        e_opc = sb[i]; e_done = 1; e_cons = i + 1; return;
      end
      if (i + 1 >= sn) begin e_trunc = 1; e_cons = sn; return; end
      v0 = sb[i]; v1 = sb[i+1];
      if (sb[i] == 8'hC4) begin
        if (i + 2 >= sn) begin e_trunc = 1; e_cons = sn; return; end
        v2 = sb[i+2]; e_vlen = 3;
        if (m && v2[7]) e_opnd = 8;
        i += 3;
      end else begin
        v2 = v1 & 8'h7F; e_vlen = 2;
        i += 2;
      end
      if (i >= sn) begin e_trunc = 1; e_cons = sn; return; end
    end
    e_opc = sb[i]; e_done = 1; e_cons = i + 1;
  endtask

  task automatic verify(input int cons);
    chk(done == e_done && trunc_err == e_trunc && excess_err == e_exc, "R5/R10 outcome",
        {29'd0, done, trunc_err, excess_err}, {29'd0, e_done, e_trunc, e_exc});
    chk(cons == e_cons, "R8 bytes accepted", cons, e_cons);
    chk(!in_ready, "R11 ready after finish", in_ready, 0);
    if (e_done) begin
      chk(opcode == e_opc, "R11 opcode", opcode, e_opc);
      chk(pfx_slots == {es[3], es[2], es[1], es[0]}, "R6 slots", pfx_slots, {es[3], es[2], es[1], es[0]});
      chk(pfx_cnt == e_cnt, "R4 count", pfx_cnt, e_cnt);
      chk(last_pfx == e_last, "R6 last prefix", last_pfx, e_last);
      chk(addr_size == e_addr, "R2 address size", addr_size, e_addr);
      chk(opnd_size == e_opnd, "R3 operand size", opnd_size, e_opnd);
      chk({rex_seen, rex_byte} == {e_rexs, e_rex}, "R7 rex", {rex_seen, rex_byte}, {e_rexs, e_rex});
      chk(vex_len == e_vlen, "R9 vex length", vex_len, e_vlen);
      if (e_vlen != 0)
        chk(vex_bytes == {v2, v1, v0}, "R9 vex bytes", vex_bytes, {v2, v1, v0});
    end
  endtask

  task automatic run_seq(input bit m, input bit g);
    int idx = 0, guard = 0;
    bit fin = 0, acc;
    @(negedge clk);
    mode64 = m; start = 1; in_valid = 0; in_last = 0;
    @(negedge clk);
    start = 0;
    while (!fin && guard < 64) begin
      if (idx < sn && !(g && guard % 3 == 1)) begin
        in_valid = 1; in_data = sb[idx]; in_last = (idx == sn - 1);
      end else begin
        in_valid = 0; in_last = 0;
      end
      #1 acc = in_valid && in_ready;
      @(posedge clk); #1;
      if (acc) idx++;
      fin = done || trunc_err || excess_err;
      guard++;
      @(negedge clk);
    end
    #1;
    model(m);
    verify(idx);
    in_valid = 0; in_last = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL R11 watchdog act=running exp=finished");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    rst = 1; start = 0; mode64 = 0; in_valid = 0; in_data = 0; in_last = 0;
    repeat (3) @(negedge clk);
    #1;
    // R1 reset state
    chk(!done && !trunc_err && !excess_err && !in_ready && pfx_cnt == 0, "R1 reset flags",
        {done, trunc_err, excess_err, in_ready, pfx_cnt}, 0);
    chk(addr_size == 4 && opnd_size == 4, "R1 reset sizes", {addr_size, opnd_size}, 8'h44);
    @(negedge clk); rst = 0;

    // R1 start defaults in both modes
    for (int m = 0; m < 2; m++) begin
      @(negedge clk); mode64 = m[0]; start = 1;
      @(negedge clk); start = 0; #1;
      chk(addr_size == (m ? 8 : 4) && opnd_size == 4 && pfx_cnt == 0, "R1 start defaults",
          {addr_size, opnd_size}, {(m ? 4'd8 : 4'd4), 4'd4});
    end

    // R2 R3 R4 R6: every ordered pair of prefixes, both modes
    for (int m = 0; m < 2; m++)
      for (int a = 0; a < 11; a++)
        for (int b = 0; b < 11; b++) begin
          sn = 0; put(lp[a]); put(lp[b]); put(8'h90);
          run_seq(m[0], ((a + b) % 4) == 0);
        end

    // R5 five distinct; R6 swap with full slots; four then a repeat
    for (int s = 0; s < 11; s++) begin
      sn = 0;
      for (int k = 0; k < 5; k++) put(lp[(s + k) % 11]);
      put(8'h90);
      run_seq(s[0], 1'b0);
      sn = 0;
      for (int k = 0; k < 4; k++) put(lp[(s + k) % 11]);
      put(lp[s]); put(lp[(s + 2) % 11]); put(8'h0F);
      run_seq(s[1], s[0]);
    end

    // R7 REX sweep
    for (int m = 0; m < 2; m++)
      for (int r = 0; r < 16; r++) begin
        sn = 0; put(8'h67); put(8'h40 | r[7:0]); put(8'h90);
        run_seq(m[0], 1'b0);
        sn = 0; put(8'h40 | r[7:0]); put(8'h66); put(8'h90);
        run_seq(m[0], r[0]);
      end

    // R8 R9 VEX sweep over operand-byte top bits and W
    for (int m = 0; m < 2; m++)
      for (int l = 0; l < 2; l++)
        for (int k = 0; k < 16; k++) begin
          sn = 0;
          if (k[1]) put(8'h66);
          if (m == 1 && k[2]) put(8'h48);
          put(l ? 8'hC4 : 8'hC5);
          put({k[3:0], 4'h5});
          if (l) put(k[0] ? 8'h80 : 8'h78);
          put(8'h58);
          run_seq(m[0], k[3]);
        end

    // R10 truncation and lone lead bytes
    for (int m = 0; m < 2; m++) begin
      sn = 0; put(8'h66); put(8'hF3); run_seq(m[0], 1'b0);
      sn = 0; put(8'h67); run_seq(m[0], 1'b1);
      sn = 0; put(8'h48); run_seq(m[0], 1'b0);
      sn = 0; put(8'hC5); put(8'hE0); run_seq(m[0], 1'b0);
      sn = 0; put(8'hC4); put(8'hE0); put(8'h80); run_seq(m[0], 1'b0);
      sn = 0; put(8'hC4); run_seq(m[0], 1'b0);
      sn = 0; put(8'h66); put(8'h4C); put(8'hC5); put(8'hF8); run_seq(m[0], 1'b1);
    end

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule